// File: doc/BRIEF.md
# Keyboard Interrupt Unit with Sticky Per-Bit Flags

This block watches a parameterised group of key input lines (eight by default) and turns activity on them into a single interrupt request. Every line first passes through a two-flop synchroniser. A per-line mode bit then chooses how the line is watched. In level mode a line is flagged for as long as it sits at a chosen level. In edge mode a line is flagged once, when it moves toward the chosen polarity. The matching flag bit latches when its condition is seen.

A latched flag stays set until software clears that bit. Reading the flag register does not clear it. Clearing is per bit: a write of 1 clears that bit. When several keys are pending, a service routine can therefore clear one flag at a time and take one interrupt for each flag. Each line also has an enable bit. The interrupt output is the registered OR of all enabled flags.

The block has four registers on a small synchronous bus:

| Address | Register |
|---|---|
| 0 | Flag register (write 1 to clear) |
| 1 | Enable register |
| 2 | Level-select register |
| 3 | Mode register |

Top module: `kbi_top`

## Requirements
- R1: While `rst` is high and in the cycle after, all four registers read as zero and `irq` is 0. The synchroniser stages are reset to the idle-high level (all ones), so lines that rest high raise no flag after reset.
- R2: In level mode (mode bit 0), a flag bit is set on every clock where the synchronised line equals its level-select bit. Level-select 1 means high and 0 means low.
- R3: In edge mode (mode bit 1), a flag bit is set only on a synchronised transition toward its level-select bit. Level-select 1 means a rising edge and 0 means a falling edge. A steady line sets nothing.
- R4: A line change applied before clock edge k sets its flag at edge k+2. The new flag appears on `bus_rdata` (address 0 held) after edge k+3, and on `irq` after edge k+3.
- R5: Reading the flag register, and any time passing without a clear, leaves set flag bits set.
- R6: A write to address 0 clears exactly the flag bits where `bus_wdata` is 1. Bits written 0 are unchanged.
- R7: If a bit's set condition and a clear of that bit happen at the same edge, the flag ends up set.
- R8: `irq` equals, one clock later, the OR over all bits of (flag AND enable).
- R9: Writes to addresses 1, 2 and 3 load the enable, level-select and mode registers. A read of any address returns that register's value on `bus_rdata` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | NUM_KEYS | Asynchronous key lines |
| bus_addr | input | 2 | Register address (0 flag, 1 enable, 2 level-select, 3 mode) |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | NUM_KEYS | Write data |
| bus_rdata | output | NUM_KEYS | Registered read data for the address of the previous cycle |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach is a software clear that lands on the exact edge where the same bit's set condition fires. To hit it, the stimulus changes an edge-mode line and then counts edges through the synchroniser, so that the clear write is issued on the second edge after the change. The per-flag servicing pattern is built by leaving several flags pending under different enable masks. Those flags are then retired one bit at a time, and `irq` must stay high until the last enabled one is gone. A behavioural model, clocked next to the design, checks the timing of every flag and read on every cycle.

// File: rtl/kbi_pkg.sv
package kbi_pkg;
  localparam int unsigned KBI_ADDR_W = 2;

  typedef enum logic [KBI_ADDR_W-1:0] {
    KR_FLAG   = 2'd0,
    KR_ENABLE = 2'd1,
    KR_LEVEL  = 2'd2,
    KR_MODE   = 2'd3
  } kbi_reg_e;
endpackage

// File: rtl/kbi_sync.sv
module kbi_sync #(
  parameter int unsigned W        = 8,
  parameter int unsigned STAGES   = 2,
  parameter bit          IDLE_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] RST_VEC = {W{IDLE_LVL}};

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VEC;
        else     stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VEC;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/kbi_detect.sv
module kbi_detect #(
  parameter int unsigned W        = 8,
  parameter bit          IDLE_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line_s,
  input  logic [W-1:0] polarity,
  input  logic [W-1:0] edge_mode,
  output logic [W-1:0] set_vec
);
  localparam logic [W-1:0] RST_VEC = {W{IDLE_LVL}};

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VEC;
    else     prev_q <= line_s;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic lvl_hit;
    logic edg_hit;
    always_comb begin
      lvl_hit = (line_s[b] == polarity[b]);
      edg_hit = polarity[b] ? (line_s[b] & ~prev_q[b])
                            : (~line_s[b] & prev_q[b]);
      set_vec[b] = edge_mode[b] ? edg_hit : lvl_hit;
    end
  end
endmodule

// File: rtl/kbi_regs.sv
module kbi_regs
  import kbi_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic [KBI_ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]          bus_wdata,
  input  logic [W-1:0]          set_vec,
  output logic [W-1:0]          clr_vec,
  output logic [W-1:0]          flag_q,
  output logic [W-1:0]          en_q,
  output logic [W-1:0]          pol_q,
  output logic [W-1:0]          mode_q,
  output logic [W-1:0]          rdata_q
);
  kbi_reg_e sel;

  assign sel     = kbi_reg_e'(bus_addr);
  assign clr_vec = (bus_wr && sel == KR_FLAG) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        KR_ENABLE: en_q   <= bus_wdata;
        KR_LEVEL:  pol_q  <= bus_wdata;
        KR_MODE:   mode_q <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (sel)
        KR_FLAG:   rdata_q <= flag_q;
        KR_ENABLE: rdata_q <= en_q;
        KR_LEVEL:  rdata_q <= pol_q;
        default:   rdata_q <= mode_q;
      endcase
    end
  end
endmodule

// File: rtl/kbi_top.sv
module kbi_top
  import kbi_pkg::*;
#(
  parameter int unsigned NUM_KEYS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_KEYS-1:0]   key_in,
  input  logic [KBI_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [NUM_KEYS-1:0]   bus_wdata,
  output logic [NUM_KEYS-1:0]   bus_rdata,
  output logic                  irq
);
  localparam bit IDLE_LVL = 1'b1;

  logic [NUM_KEYS-1:0] key_s;
  logic [NUM_KEYS-1:0] set_vec;
  logic [NUM_KEYS-1:0] clr_vec;
  logic [NUM_KEYS-1:0] flag_q;
  logic [NUM_KEYS-1:0] en_q;
  logic [NUM_KEYS-1:0] pol_q;
  logic [NUM_KEYS-1:0] mode_q;
  logic                irq_q;

  kbi_sync #(.W(NUM_KEYS), .STAGES(SYNC_STAGES), .IDLE_LVL(IDLE_LVL)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (key_in),
    .dout(key_s)
  );

  kbi_detect #(.W(NUM_KEYS), .IDLE_LVL(IDLE_LVL)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .line_s   (key_s),
    .polarity (pol_q),
    .edge_mode(mode_q),
    .set_vec  (set_vec)
  );

  kbi_regs #(.W(NUM_KEYS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .flag_q   (flag_q),
    .en_q     (en_q),
    .pol_q    (pol_q),
    .mode_q   (mode_q),
    .rdata_q  (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_q & en_q);
  end

  assign irq = irq_q;
endmodule

// File: rtl/kbi_checker.sv
module kbi_checker
  import kbi_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic [KBI_ADDR_W-1:0] bus_addr,
  input logic [W-1:0]          bus_wdata,
  input logic [W-1:0]          set_vec,
  input logic [W-1:0]          clr_vec,
  input logic [W-1:0]          flag_q,
  input logic [W-1:0]          en_q,
  input logic                  irq
);
  // R1: reset empties the flags and drops the request
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (flag_q == '0 && irq == 1'b0));

  // R5: a set flag survives any cycle without a clear for it
  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flag_q) & ~$past(clr_vec) & ~flag_q) == '0));

  // R6: a cleared bit with no set condition goes low
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & $past(clr_vec) & ~$past(set_vec)) == '0));

  // R7: a set condition always leaves the flag high, even under clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(set_vec) & ~flag_q) == '0));

  // R8: request follows enabled flags one clock later
  assert_irq_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(flag_q) & $past(en_q))));

  // R9: an enable write is visible next cycle
  assert_enable_load_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == KR_ENABLE) |=> (en_q == $past(bus_wdata)));
endmodule

bind kbi_top kbi_checker #(.W(NUM_KEYS)) u_kbi_checker (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .flag_q   (flag_q),
  .en_q     (en_q),
  .irq      (irq)
);

// File: tb/tb_kbi_top.sv
`timescale 1ns/100ps
module tb_kbi_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] key_in = '1;
  logic [1:0]   bus_addr = 2'd0;
  logic         bus_wr = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  kbi_top #(.NUM_KEYS(N)) dut (
    .clk(clk), .rst(rst), .key_in(key_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [N-1:0] m_s1 = '1, m_s2 = '1, m_prev = '1;
  logic [N-1:0] m_flag = '0, m_en = '0, m_pol = '0, m_mode = '0, m_rd = '0;
  logic         m_irq = 1'b0;

  always @(posedge clk) begin
    logic [N-1:0] hit, clr;
    cyc++;
    if (rst) begin
      m_s1 = '1; m_s2 = '1; m_prev = '1;
      m_flag = '0; m_en = '0; m_pol = '0; m_mode = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (m_mode[i])
          hit[i] = m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
        else
          hit[i] = (m_s2[i] == m_pol[i]);
      end
      clr = (bus_wr && bus_addr == 2'd0) ? bus_wdata : '0;
      m_irq = |(m_flag & m_en);
      case (bus_addr)
        2'd0: m_rd = m_flag;
        2'd1: m_rd = m_en;
        2'd2: m_rd = m_pol;
        default: m_rd = m_mode;
      endcase
      m_flag = (m_flag & ~clr) | hit;
      if (bus_wr && bus_addr == 2'd1) m_en = bus_wdata;
      if (bus_wr && bus_addr == 2'd2) m_pol = bus_wdata;
      if (bus_wr && bus_addr == 2'd3) m_mode = bus_wdata;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = key_in;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle against the model (R4 timing, R8 request)
  always @(negedge clk) begin
    chk(irq == m_irq, {phase, "/R8 irq"}, irq, m_irq);
    chk(bus_rdata == m_rd, {phase, "/R4 rdata"}, bus_rdata, m_rd);
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    step(1);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [N-1:0] exp, input string req);
    bus_addr = a;
    @(posedge clk); #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  initial begin
    step(4);
    chk(irq == 1'b0, "R1 irq in reset", irq, 0);
    chk(bus_rdata == '0, "R1 rdata in reset", bus_rdata, 0);
    rst = 1'b0;
    step(4);
    for (int a = 0; a < 4; a++) rd_chk(a[1:0], '0, "R1 register zero");

    // level mode
    phase = "R2";
    wr(2'd2, 8'hA5);
    rd_chk(2'd2, 8'hA5, "R9 level-select readback");
    step(4);
    rd_chk(2'd0, 8'hA5, "R2 high-level flags");
    phase = "R7";
    wr(2'd0, 8'hA5);
    rd_chk(2'd0, 8'hA5, "R7 level clear loses to set");
    phase = "R5";
    key_in = 8'h5A;
    step(3);
    wr(2'd0, 8'h00);
    step(4);
    rd_chk(2'd0, 8'hA5, "R5 sticky after line leaves level");
    rd_chk(2'd0, 8'hA5, "R5 read does not clear");
    phase = "R6";
    wr(2'd0, 8'h01);
    rd_chk(2'd0, 8'hA4, "R6 single-bit clear");
    wr(2'd0, 8'hFF);
    rd_chk(2'd0, 8'h00, "R6 clear all");

    // edge mode
    phase = "R3";
    wr(2'd3, 8'hFF);
    wr(2'd2, 8'h0F);
    rd_chk(2'd3, 8'hFF, "R9 mode readback");
    step(4);
    rd_chk(2'd0, 8'h00, "R3 steady lines set nothing");
    phase = "R4";
    key_in = 8'hA5;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(bus_rdata == (i < 3 ? 8'h00 : 8'h55), "R4 edge latency", bus_rdata, (i < 3 ? 0 : 8'h55));
    end
    step(4);
    rd_chk(2'd0, 8'h55, "R3 rising/falling by polarity");

    // request and per-flag service
    phase = "R8";
    step(2);
    chk(irq == 1'b0, "R8 no enable no request", irq, 0);
    wr(2'd1, 8'h04);
    step(2);
    chk(irq == 1'b1, "R8 enabled flag raises request", irq, 1);
    wr(2'd0, 8'h04);
    step(2);
    chk(irq == 1'b0, "R8 request drops after clear", irq, 0);
    wr(2'd1, 8'h11);
    step(2);
    chk(irq == 1'b1, "R8 two pending", irq, 1);
    wr(2'd0, 8'h01);
    step(2);
    chk(irq == 1'b1, "R8 one still pending", irq, 1);
    wr(2'd0, 8'h10);
    step(2);
    chk(irq == 1'b0, "R8 all serviced", irq, 0);
    rd_chk(2'd0, 8'h40, "R6 remaining flag");

    // clear on the same edge as an edge set
    phase = "R7";
    key_in = 8'hA7;
    step(2);
    wr(2'd0, 8'h02);
    step(2);
    rd_chk(2'd0, 8'h42, "R7 edge set beats clear");

    step(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule